// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins a set of open-drain lines that run between a controller and a card. Each lane has a controller side and a card side. A low pulled on either side is copied to the other side, so the bus needs no direction pin. On each side the block reads the sampled line level and drives two enables: a pull-low enable for an open-drain transistor and a pull-high enable for a short active pull-up. Both lines rest high through passive resistors outside the block. The default configuration has three lanes: one for the data line and two for auxiliary lines.

Each lane runs a small state machine. States are `ST_IDLE`, `ST_H_WAIT`, `ST_H_HOLD`, `ST_H_BOOST`, `ST_C_WAIT`, `ST_C_HOLD`, `ST_C_BOOST` and `ST_OFF`. In `ST_IDLE`, a falling edge on the controller side moves the lane to `ST_H_WAIT`, and a falling edge on the card side moves it to `ST_C_WAIT`. When both sides fall in the same cycle, the controller side wins. A WAIT state moves to its HOLD state when the edge delay expires, or back to `ST_IDLE` if the master side is already high again. A HOLD state moves to its BOOST state when the master side goes high. A BOOST state returns to `ST_IDLE` when the pulse counter expires. Raising the global disable sends every lane to `ST_OFF` from any state. `ST_OFF` moves to `ST_IDLE` once the disable drops. While a lane is in a WAIT, HOLD or BOOST state it ignores edges on the slave side, so the low it repeats itself never reflects back.

Both line inputs pass through a two-flop synchronizer. The edge delay and the pulse length are counted in system clocks. The counter width is derived from the number of clocks in half of a 1 MHz line period.

Top module: `line_relay`

## Requirements
- R1: After reset, and whenever a lane is idle, all four drive enables of that lane are 0. Line value 1 means high.
- R2: Take the rising clock edge that first samples a controller-side fall as edge 1. The card-side pull-low of that lane asserts after edge EDGE_DLY+3 and stays on while the controller line stays low.
- R3: A card-side fall in idle is repeated in the same way. The controller-side pull-low asserts after edge EDGE_DLY+3.
- R4: Take the edge that first samples the master side high again as edge 1. After edge 3 the slave pull-low drops and the slave pull-high asserts for exactly PULSE_LEN cycles. The lane is then idle.
- R5: If the master side is low for EDGE_DLY clock cycles or fewer, nothing is driven on either side.
- R6: During a transfer, a fall on the slave side, whether it is the repeated low itself or a low from outside, does not change direction. The master side is never driven.
- R7: If both sides fall in the same sample cycle, the controller side is master and only the card side is driven.
- R8: While the disable input is 1, from the next edge every card-side pull-low is 1 and every other enable is 0, whatever the lines do. This holds even in the middle of a transfer.
- R9: The pull-low and pull-high enables of one side are never 1 together, and the two sides are never pulled low together outside disable.
- R10: A transfer on one lane leaves the enables of every other lane at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| relay_off | input | 1 | Global disable: card sides held low, controller sides released |
| host_line | input | NUM_LANES | Sampled controller-side line levels |
| card_line | input | NUM_LANES | Sampled card-side line levels |
| host_pull_lo | output | NUM_LANES | Controller-side pull-low enables |
| host_pull_hi | output | NUM_LANES | Controller-side active pull-up enables |
| card_pull_lo | output | NUM_LANES | Card-side pull-low enables |
| card_pull_hi | output | NUM_LANES | Card-side active pull-up enables |

## Verification
The hardest case to reach is the lockout: a genuine low from outside on the slave side that arrives while the lane is already repeating the other side. From the ports it looks just like the block's own echo. The bench models the wired-AND of each line. It starts a controller-side transfer, then pulls the card line low from outside after the lane has committed and keeps it low beyond the master's release. It then checks that the controller side is never driven and that the boost and return to idle keep their normal timing. A sweep over master low lengths from 1 to 10 cycles, on every lane and in both directions, covers the point where a transfer is too short to be repeated.

// File: rtl/relay_pkg.sv
package relay_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_H_WAIT,
        ST_H_HOLD,
        ST_H_BOOST,
        ST_C_WAIT,
        ST_C_HOLD,
        ST_C_BOOST,
        ST_OFF
    } relay_state_e;
endpackage

// File: rtl/relay_sync.sv
module relay_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // Lines idle high, so reset to all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/relay_lane.sv
module relay_lane
    import relay_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int EDGE_DLY  = 4,
    parameter int PULSE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_i,
    input  logic host_s,
    input  logic card_s,
    output logic host_lo,
    output logic host_hi,
    output logic card_lo,
    output logic card_hi
);
    localparam logic [CNT_W-1:0] DLY_LOAD   = CNT_W'(EDGE_DLY - 1);
    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_LEN - 1);

    relay_state_e     state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             host_prev, card_prev;
    logic             host_fall, card_fall;

    assign host_fall = host_prev & ~host_s;
    assign card_fall = card_prev & ~card_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_prev <= 1'b1;
            card_prev <= 1'b1;
        end else begin
            host_prev <= host_s;
            card_prev <= card_s;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (off_i) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (host_fall) begin
                        state_nxt = ST_H_WAIT;
                        cnt_nxt   = DLY_LOAD;
                    end else if (card_fall) begin
                        state_nxt = ST_C_WAIT;
                        cnt_nxt   = DLY_LOAD;
                    end
                end
                ST_H_WAIT: begin
                    if (host_s)          state_nxt = ST_IDLE;
                    else if (cnt == '0)  state_nxt = ST_H_HOLD;
                    else                 cnt_nxt   = cnt - CNT_W'(1);
                end
                ST_H_HOLD: begin
                    if (host_s) begin
                        state_nxt = ST_H_BOOST;
                        cnt_nxt   = PULSE_LOAD;
                    end
                end
                ST_H_BOOST: begin
                    if (cnt == '0) state_nxt = ST_IDLE;
                    else           cnt_nxt   = cnt - CNT_W'(1);
                end
                ST_C_WAIT: begin
                    if (card_s)          state_nxt = ST_IDLE;
                    else if (cnt == '0)  state_nxt = ST_C_HOLD;
                    else                 cnt_nxt   = cnt - CNT_W'(1);
                end
                ST_C_HOLD: begin
                    if (card_s) begin
                        state_nxt = ST_C_BOOST;
                        cnt_nxt   = PULSE_LOAD;
                    end
                end
                ST_C_BOOST: begin
                    if (cnt == '0) state_nxt = ST_IDLE;
                    else           cnt_nxt   = cnt - CNT_W'(1);
                end
                ST_OFF: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        host_lo = 1'b0;
        host_hi = 1'b0;
        card_lo = 1'b0;
        card_hi = 1'b0;
        unique case (state)
            ST_H_HOLD:  card_lo = 1'b1;
            ST_H_BOOST: card_hi = 1'b1;
            ST_C_HOLD:  host_lo = 1'b1;
            ST_C_BOOST: host_hi = 1'b1;
            ST_OFF:     card_lo = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/line_relay.sv
module line_relay #(
    parameter int NUM_LANES = 3,
    parameter int CLK_MHZ   = 50,
    parameter int EDGE_DLY  = 4,
    parameter int PULSE_LEN = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 relay_off,
    input  logic [NUM_LANES-1:0] host_line,
    input  logic [NUM_LANES-1:0] card_line,
    output logic [NUM_LANES-1:0] host_pull_lo,
    output logic [NUM_LANES-1:0] host_pull_hi,
    output logic [NUM_LANES-1:0] card_pull_lo,
    output logic [NUM_LANES-1:0] card_pull_hi
);
    // Clocks in half of a 1 MHz line period bound the delay plus pulse
    localparam int HALF_WIN = CLK_MHZ / 2;
    localparam int CNT_W    = $clog2(HALF_WIN + 1);

    logic [NUM_LANES-1:0] host_s;
    logic [NUM_LANES-1:0] card_s;

    relay_sync #(.WIDTH(NUM_LANES)) u_host_sync (
        .clk(clk), .rst_n(rst_n), .d_i(host_line), .q_o(host_s)
    );

    relay_sync #(.WIDTH(NUM_LANES)) u_card_sync (
        .clk(clk), .rst_n(rst_n), .d_i(card_line), .q_o(card_s)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        relay_lane #(
            .CNT_W(CNT_W), .EDGE_DLY(EDGE_DLY), .PULSE_LEN(PULSE_LEN)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .off_i(relay_off),
            .host_s(host_s[g]), .card_s(card_s[g]),
            .host_lo(host_pull_lo[g]), .host_hi(host_pull_hi[g]),
            .card_lo(card_pull_lo[g]), .card_hi(card_pull_hi[g])
        );
    end
endmodule

// File: rtl/relay_chk.sv
module relay_chk #(
    parameter int NL = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          relay_off,
    input logic [NL-1:0] host_pull_lo,
    input logic [NL-1:0] host_pull_hi,
    input logic [NL-1:0] card_pull_lo,
    input logic [NL-1:0] card_pull_hi
);
    // R8
    off_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        relay_off |=> (card_pull_lo == '1 && host_pull_lo == '0 &&
                       host_pull_hi == '0 && card_pull_hi == '0));

    for (genvar i = 0; i < NL; i++) begin : g_chk
        // R9
        side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(host_pull_lo[i] && host_pull_hi[i]) && !(card_pull_lo[i] && card_pull_hi[i]));
        // R9
        one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(host_pull_lo[i] && card_pull_lo[i]));
        // R4
        card_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(card_pull_hi[i]) |-> $past(card_pull_lo[i]));
        // R4
        host_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(host_pull_hi[i]) |-> $past(host_pull_lo[i]));
        // R4
        boost_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(card_pull_hi[i]) |-> !host_pull_lo[i] && !host_pull_hi[i]);
    end
endmodule

bind line_relay relay_chk #(.NL(NUM_LANES)) u_relay_chk (
    .clk(clk), .rst_n(rst_n), .relay_off(relay_off),
    .host_pull_lo(host_pull_lo), .host_pull_hi(host_pull_hi),
    .card_pull_lo(card_pull_lo), .card_pull_hi(card_pull_hi)
);

// File: tb/sim_line_relay.sv
module sim_line_relay;
    localparam int NL = 3;
    localparam int D  = 4;
    localparam int P  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          relay_off = 1'b0;
    logic [NL-1:0] host_ext = '1;
    logic [NL-1:0] card_ext = '1;
    logic [NL-1:0] host_line, card_line;
    logic [NL-1:0] host_pull_lo, host_pull_hi, card_pull_lo, card_pull_hi;
    int            n_checks = 0;
    int            n_fail = 0;
    int            wd_cnt = 0;

    always #10 clk = ~clk;

    // Wired-AND line model with passive pull-ups
    assign host_line = host_ext & ~host_pull_lo;
    assign card_line = card_ext & ~card_pull_lo;

    line_relay #(.NUM_LANES(NL), .CLK_MHZ(50), .EDGE_DLY(D), .PULSE_LEN(P)) u0 (
        .clk(clk), .rst_n(rst_n), .relay_off(relay_off),
        .host_line(host_line), .card_line(card_line),
        .host_pull_lo(host_pull_lo), .host_pull_hi(host_pull_hi),
        .card_pull_lo(card_pull_lo), .card_pull_hi(card_pull_hi)
    );

    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [4*NL-1:0] act, input logic [4*NL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [4*NL-1:0] outs();
        return {host_pull_lo, host_pull_hi, card_pull_lo, card_pull_hi};
    endfunction

    // One transfer on a lane; master low for lowlen cycles
    task automatic run_xfer(input int lane, input bit card_master, input int lowlen);
        int r;
        bit rep;
        r   = lowlen + 3;
        rep = (lowlen > D);
        if (card_master) card_ext[lane] = 1'b0; else host_ext[lane] = 1'b0;
        for (int t = 1; t <= lowlen + P + 6; t++) begin
            logic [NL-1:0] e_hlo, e_hhi, e_clo, e_chi, msk;
            logic          lo_on, hi_on;
            string         tag;
            step();
            lo_on = rep && (t >= 3 + D) && (t < r);
            hi_on = rep && (t >= r) && (t < r + P);
            e_hlo = '0; e_hhi = '0; e_clo = '0; e_chi = '0;
            if (card_master) begin
                e_hlo[lane] = lo_on; e_hhi[lane] = hi_on;
            end else begin
                e_clo[lane] = lo_on; e_chi[lane] = hi_on;
            end
            if (!rep)                tag = "R5 short low";
            else if (t >= r)         tag = "R4 release boost";
            else if (card_master)    tag = "R3 card master";
            else                     tag = "R2 host master";
            msk = '0;
            msk[lane] = 1'b1;
            check(tag, {host_pull_lo & msk, host_pull_hi & msk, card_pull_lo & msk, card_pull_hi & msk},
                  {e_hlo, e_hhi, e_clo, e_chi});
            // R10: other lanes untouched
            check("R10 lane isolation",
                  {host_pull_lo & ~msk, host_pull_hi & ~msk, card_pull_lo & ~msk, card_pull_hi & ~msk}, '0);
            if (t == lowlen) begin
                host_ext[lane] = 1'b1;
                card_ext[lane] = 1'b1;
            end
        end
        repeat (3) step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", outs(), '0);
        rst_n = 1'b1;
        step();
        check("R1 idle after reset", outs(), '0);

        for (int lane = 0; lane < NL; lane++)
            for (int dir = 0; dir < 2; dir++)
                for (int len = 1; len <= 10; len++)
                    run_xfer(lane, dir[0], len);

        // R6: outside low on card side after host took mastership
        host_ext[0] = 1'b0;
        for (int t = 1; t <= 20; t++) begin
            logic [NL-1:0] e_clo, e_chi;
            step();
            e_clo = '0; e_chi = '0;
            e_clo[0] = (t >= 7) && (t < 11);
            e_chi[0] = (t >= 11) && (t < 14);
            check("R6 anti-latch lockout", outs(), {3'b000, 3'b000, e_clo, e_chi});
            if (t == 4)  card_ext[0] = 1'b0;
            if (t == 8)  host_ext[0] = 1'b1;
            if (t == 12) card_ext[0] = 1'b1;
        end
        repeat (3) step();

        // R7: simultaneous fall on lane 2
        host_ext[2] = 1'b0;
        card_ext[2] = 1'b0;
        for (int t = 1; t <= 18; t++) begin
            logic [NL-1:0] e_clo, e_chi;
            step();
            e_clo = '0; e_chi = '0;
            e_clo[2] = (t >= 7) && (t < 11);
            e_chi[2] = (t >= 11) && (t < 14);
            check("R7 tie goes to host", outs(), {3'b000, 3'b000, e_clo, e_chi});
            if (t == 8) begin
                host_ext[2] = 1'b1;
                card_ext[2] = 1'b1;
            end
        end
        repeat (3) step();

        // R8: disable while idle, lines wiggled
        relay_off = 1'b1;
        step();
        check("R8 disable pattern", outs(), {3'b000, 3'b000, 3'b111, 3'b000});
        host_ext[0] = 1'b0;
        for (int t = 0; t < 6; t++) begin
            step();
            check("R8 disable ignores lines", outs(), {3'b000, 3'b000, 3'b111, 3'b000});
        end
        host_ext[0] = 1'b1;
        repeat (3) step();
        relay_off = 1'b0;
        step();
        check("R8 leave disable", outs(), '0);
        for (int t = 0; t < 6; t++) begin
            step();
            check("R1 idle after disable", outs(), '0);
        end

        // R8: disable in the middle of a hold on lane 1
        host_ext[1] = 1'b0;
        repeat (8) step();
        check("R2 hold before disable", outs(), {3'b000, 3'b000, 3'b010, 3'b000});
        relay_off = 1'b1;
        step();
        check("R8 disable mid transfer", outs(), {3'b000, 3'b000, 3'b111, 3'b000});
        host_ext[1] = 1'b1;
        repeat (3) step();
        relay_off = 1'b0;
        step();
        check("R8 release mid transfer", outs(), '0);
        for (int t = 0; t < 5; t++) begin
            step();
            check("R9 quiet after disable", outs(), '0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule